// File: doc/BRIEF.md
# Baud Generator with Digital Clock Recovery

This block produces the receive bit timing for one synchronous serial channel. A programmable down-counter runs on the system clock and toggles its output each time it reaches zero. The time constant is chosen so that the toggles come at sixteen times the nominal bit rate, and each toggle counts as one sixteenth-of-a-bit tick. A digital phase-locked loop counts these ticks in a bit-phase counter. The counter restarts from zero whenever the raw receive line changes level. When it reaches the middle of the bit, the loop emits a one-cycle receive strobe, so the strobe lands half a bit after the most recent transition. With no transitions, the strobe keeps recurring once every sixteen ticks.

The raw line is sampled through a two-flop synchronizer before NRZI decoding or any other processing. The receive strobe is a clock-enable pulse one system clock wide, not a separate clock net. The time constant is supplied as a low byte and a high byte, and a new value is picked up at the generator's next reload. While the enable is low, all counters are held cleared and both outputs stay low.

Top module: `baud_dpll`

## Requirements
- R1: While reset is asserted, and after reset until the enable is raised, `brg_out` and `rx_clk_stb` are 0.
- R2: With time constant N = {tc_hi, tc_lo} and the enable high, `brg_out` first toggles on the first enabled clock edge. After that it toggles every N+1 clock cycles: the counter counts N down to 0, toggles, and reloads N on that same edge.
- R3: A change of `tc_hi` or `tc_lo` does not alter the countdown in progress. The new value is loaded at the next reload.
- R4: `rxd_raw` passes through two synchronizing flops. A level change seen at the synchronizer output clears the bit-phase counter to 0 on the following edge.
- R5: `rx_clk_stb` is a pulse exactly one clock wide. It is raised on the edge that carries the eighth tick after the clearing transition. With N=0 (one tick per cycle), a change on `rxd_raw` driven between edges gives a strobe visible 11 clock cycles later.
- R6: Without transitions, the phase counter advances once per `brg_out` toggle and wraps after 16 ticks, so strobes recur every 16 ticks (16 clocks when N=0).
- R7: When a transition and the tick that would reach mid-bit fall in the same cycle, the transition wins. The counter clears and no strobe is issued. A line toggling every 8 clocks with N=0 therefore yields no strobes.
- R8: With N=0, `brg_out` toggles on every clock cycle.
- R9: When the enable is lowered, `brg_out` and `rx_clk_stb` are 0 after the next edge and both counters are cleared. On re-enable, operation starts afresh as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_lo | input | 8 | Time constant, low byte |
| tc_hi | input | 8 | Time constant, high byte |
| enable | input | 1 | Runs the generator and the phase loop when high |
| rxd_raw | input | 1 | Raw receive line, asynchronous |
| brg_out | output | 1 | Generator output, toggles at the 16x tick rate |
| rx_clk_stb | output | 1 | One-cycle mid-bit receive strobe |

## Verification
The transition that clears the phase counter can land in the same cycle as the tick that would take the counter to mid-bit. In that cycle the clear and the strobe compete. The bench provokes this by running the generator at one tick per clock and toggling the raw line every eight clocks, which puts each clearing transition exactly on the would-be mid-bit tick. It judges the result in three ways: no strobe may appear at the port during that window, the reference model must have counted at least one such collision, and the per-cycle comparison against the model must hold. Neighbouring toggle periods and a random line pattern then exercise the near misses on either side.

// File: rtl/baud_dpll_pkg.sv
package baud_dpll_pkg;

  // Next value of a bit-phase counter that wraps after 'ratio' ticks.
  function automatic int unsigned phase_advance(int unsigned ph, int unsigned ratio);
    return (ph + 1 >= ratio) ? 0 : ph + 1;
  endfunction

  // True when the next tick takes the counter to the mid-bit count.
  function automatic logic phase_before_mid(int unsigned ph, int unsigned ratio);
    return ph == (ratio / 2) - 1;
  endfunction

  // Next generator count: reload on zero, otherwise count down.
  function automatic int unsigned gen_step(int unsigned cnt, int unsigned tc);
    return (cnt == 0) ? tc : cnt - 1;
  endfunction

endpackage

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int TC_W   = 16,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [BYTE_W-1:0]      tc_lo,
  input  logic [TC_W-BYTE_W-1:0] tc_hi,
  output logic                   brg_out,
  output logic                   tick_ev,
  output logic                   zero_ev,
  output logic [TC_W-1:0]        cnt_q,
  output logic [TC_W-1:0]        tc_w
);
  import baud_dpll_pkg::*;

  logic brg_d;

  assign tc_w    = {tc_hi, tc_lo};
  assign zero_ev = en && (cnt_q == '0);
  assign tick_ev = brg_out ^ brg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      brg_out <= 1'b0;
      brg_d   <= 1'b0;
    end else begin
      brg_d <= brg_out;
      if (!en) begin
        cnt_q   <= '0;
        brg_out <= 1'b0;
      end else begin
        cnt_q <= TC_W'(gen_step(32'(cnt_q), 32'(tc_w)));
        if (zero_ev) brg_out <= ~brg_out;
      end
    end
  end

endmodule

// File: rtl/rx_sync_edge.sv
module rx_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rxd_raw,
  output logic trans_ev
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= rxd_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], rxd_raw};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[SYNC_STAGES-1];
  end

  assign trans_ev = en && (chain_q[SYNC_STAGES-1] ^ prev_q);

endmodule

// File: rtl/dpll_phase.sv
module dpll_phase #(
  parameter int RATIO = 16,
  localparam int PH_W = $clog2(RATIO)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick_ev,
  input  logic            trans_ev,
  output logic [PH_W-1:0] phase_q,
  output logic            mid_ev,
  output logic            stb_q
);
  import baud_dpll_pkg::*;

  assign mid_ev = tick_ev && phase_before_mid(32'(phase_q), RATIO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      stb_q   <= 1'b0;
    end else if (!en || trans_ev) begin
      phase_q <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= mid_ev;
      if (tick_ev) phase_q <= PH_W'(phase_advance(32'(phase_q), RATIO));
    end
  end

endmodule

// File: rtl/baud_dpll.sv
module baud_dpll #(
  parameter int TC_W        = 16,
  parameter int BYTE_W      = 8,
  parameter int RATIO       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PH_W       = $clog2(RATIO)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BYTE_W-1:0]      tc_lo,
  input  logic [TC_W-BYTE_W-1:0] tc_hi,
  input  logic                   enable,
  input  logic                   rxd_raw,
  output logic                   brg_out,
  output logic                   rx_clk_stb
);
  logic            tick_ev, zero_ev, trans_ev, mid_ev;
  logic [TC_W-1:0] cnt_q, tc_w;
  logic [PH_W-1:0] phase_q;

  baud_gen #(.TC_W(TC_W), .BYTE_W(BYTE_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(enable), .tc_lo(tc_lo), .tc_hi(tc_hi),
    .brg_out(brg_out), .tick_ev(tick_ev), .zero_ev(zero_ev),
    .cnt_q(cnt_q), .tc_w(tc_w)
  );

  rx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(enable), .rxd_raw(rxd_raw),
    .trans_ev(trans_ev)
  );

  dpll_phase #(.RATIO(RATIO)) u_pll (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick_ev(tick_ev),
    .trans_ev(trans_ev), .phase_q(phase_q), .mid_ev(mid_ev),
    .stb_q(rx_clk_stb)
  );

endmodule

// File: rtl/baud_dpll_chk.sv
module baud_dpll_chk #(
  parameter int TC_W  = 16,
  parameter int RATIO = 16,
  localparam int PH_W = $clog2(RATIO)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            brg_out,
  input logic            rx_clk_stb,
  input logic            tick_ev,
  input logic            zero_ev,
  input logic            trans_ev,
  input logic            mid_ev,
  input logic [TC_W-1:0] cnt_q,
  input logic [TC_W-1:0] tc_w,
  input logic [PH_W-1:0] phase_q
);
  import baud_dpll_pkg::*;

  always @(posedge clk) begin
    if (!rst_n) assert_reset_low_R1: assert (!brg_out && !rx_clk_stb);
  end

  assert_toggle_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ev |=> brg_out != $past(brg_out));

  assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ev |=> cnt_q == $past(tc_w));

  assert_clear_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trans_ev |=> phase_q == '0);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clk_stb |=> !rx_clk_stb);

  assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick_ev && !trans_ev) |=>
      phase_q == PH_W'(phase_advance(32'($past(phase_q)), RATIO)));

  assert_edge_beats_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_ev && trans_ev) |=> !rx_clk_stb);

  assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!brg_out && !rx_clk_stb && phase_q == '0));

endmodule

bind baud_dpll baud_dpll_chk #(.TC_W(TC_W), .RATIO(RATIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .brg_out(brg_out),
  .rx_clk_stb(rx_clk_stb), .tick_ev(tick_ev), .zero_ev(zero_ev),
  .trans_ev(trans_ev), .mid_ev(mid_ev), .cnt_q(cnt_q), .tc_w(tc_w),
  .phase_q(phase_q)
);

// File: tb/tb_baud_dpll.sv
module tb_baud_dpll;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tc_lo = 8'd3;
  logic [7:0] tc_hi = 8'd0;
  logic       enable = 1'b0;
  logic       rxd_raw = 1'b0;
  logic       brg_out, rx_clk_stb;

  int    checks = 0;
  int    errors = 0;
  int    collisions = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // Reference model state
  int m_cnt = 0, m_ph = 0;
  bit m_out = 0, m_outq = 0, m_stb = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;

  baud_dpll dut (
    .clk(clk), .rst_n(rst_n), .tc_lo(tc_lo), .tc_hi(tc_hi),
    .enable(enable), .rxd_raw(rxd_raw), .brg_out(brg_out),
    .rx_clk_stb(rx_clk_stb)
  );

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_out = 0; m_outq = 0; m_stb = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit tk, tr, zr;
      int old_ph;
      tk = m_out ^ m_outq;
      tr = enable && (m_s2 != m_s3);
      zr = enable && (m_cnt == 0);
      old_ph = m_ph;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = rxd_raw;
      m_outq = m_out;
      if (!enable) begin
        m_cnt = 0; m_out = 0;
      end else if (zr) begin
        m_out = !m_out; m_cnt = {tc_hi, tc_lo};
      end else m_cnt = m_cnt - 1;
      if (!enable) begin
        m_ph = 0; m_stb = 0;
      end else if (tr) begin
        if (tk && old_ph == 7) collisions++;
        m_ph = 0; m_stb = 0;
      end else if (tk) begin
        m_stb = (old_ph == 7);
        m_ph = (old_ph + 1) % 16;
      end else m_stb = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "brg_out vs model", brg_out, m_out);
      check(cur_req, "rx_clk_stb vs model", rx_clk_stb, m_stb);
    end
  end

  task automatic wait_toggle(output int n);
    logic prev;
    prev = brg_out;
    n = 0;
    do begin @(negedge clk); n++; end while (brg_out == prev && n < 5000);
  endtask

  task automatic wait_stb(input int min_n, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!(rx_clk_stb && n >= min_n) && n < 5000);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, cnt;
    // R1: outputs low in reset and before enable
    repeat (3) @(negedge clk);
    check("R1", "brg_out in reset", brg_out, 0);
    check("R1", "rx_clk_stb in reset", rx_clk_stb, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "brg_out before enable", brg_out, 0);
    check("R1", "rx_clk_stb before enable", rx_clk_stb, 0);

    // R2: first toggle at first enabled edge, then every N+1
    cur_req = "R2";
    enable = 1'b1;
    wait_toggle(n); check("R2", "first toggle delay", n, 1);
    wait_toggle(n); check("R2", "toggle interval N=3", n, 4);
    wait_toggle(n); check("R2", "toggle interval N=3", n, 4);

    // R3: new constant only at next reload
    cur_req = "R3";
    tc_lo = 8'd5;
    wait_toggle(n); check("R3", "interval keeps old N", n, 4);
    wait_toggle(n); check("R3", "interval uses new N=5", n, 6);
    tc_hi = 8'd1; tc_lo = 8'd2;
    wait_toggle(n); check("R3", "interval keeps N=5", n, 6);
    wait_toggle(n); check("R3", "high byte used, N=258", n, 259);

    // R8: N=0 toggles every cycle
    cur_req = "R8";
    tc_hi = 8'd0; tc_lo = 8'd0;
    wait_toggle(n);
    wait_toggle(n); check("R8", "toggle interval N=0", n, 1);
    wait_toggle(n); check("R8", "toggle interval N=0", n, 1);

    // R6: free-running strobe period with quiet line
    cur_req = "R6";
    wait_stb(1, n);
    wait_stb(1, n); check("R6", "strobe period quiet line", n, 16);

    // R4 R5: strobe after a line edge, through two sync flops
    cur_req = "R5";
    rxd_raw = 1'b1;
    wait_stb(3, n); check("R4", "edge to strobe latency (R5)", n, 11);
    @(negedge clk); check("R5", "strobe width one cycle", rx_clk_stb, 0);
    wait_stb(1, n); check("R6", "strobe period after edge", n, 15);

    // R7: edges landing on the mid-bit tick suppress the strobe
    cur_req = "R7";
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      rxd_raw = ~rxd_raw;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (k > 0 && rx_clk_stb) cnt++;
      end
    end
    check("R7", "strobes during collision pattern", cnt, 0);
    check("R7", "collisions provoked", int'(collisions > 0), 1);
    for (int p = 6; p <= 10; p++) begin
      for (int k = 0; k < 6; k++) begin
        rxd_raw = ~rxd_raw;
        repeat (p) @(negedge clk);
      end
    end

    // R5 R4: random line against the model at a slower tick rate
    cur_req = "R5";
    tc_lo = 8'd2;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 39) == 0) rxd_raw = ~rxd_raw;
    end

    // R9: disable clears and silences
    cur_req = "R9";
    tc_lo = 8'd0;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9", "brg_out after disable", brg_out, 0);
    check("R9", "rx_clk_stb after disable", rx_clk_stb, 0);
    repeat (5) @(negedge clk);
    cnt = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (rx_clk_stb || brg_out) cnt++;
    end
    check("R9", "outputs quiet while disabled", cnt, 0);
    tc_lo = 8'd1;
    enable = 1'b1;
    wait_toggle(n); check("R9", "restart first toggle", n, 1);
    wait_toggle(n); check("R9", "restart interval N=1", n, 2);
    repeat (200) @(negedge clk);

    finish_run();
  end
endmodule